// File: doc/BRIEF.md
# Aligned Power-of-Two Clock Divider

This block turns one input clock into a set of divided clocks at one half, one quarter and one eighth of the input rate. Every divided clock comes out as a true signal and its complement. All divider stages are advanced by the same rising input edge, so a transition on a slower output always falls on the same edge as a transition on every faster output. Several copies of the block can be brought into phase by pulsing their resets together.

A common hold input freezes all outputs. Hold is captured on the falling input edge, so the decision to advance or not is already fixed during the low half of the clock before the next rising edge arrives. A late change of hold therefore never shortens a divided pulse: it can only lengthen one by whole input cycles. The divider is built as a chain of toggle stages with clock enables, not as a gated clock, so it maps onto ordinary FPGA flip-flops.

Top module: `pow2_clk_div`

## Requirements
- R1: Output bit `div_o[k]` runs at 1/2^(k+1) of the input rate: bit 0 is the half-rate clock, bit 1 the quarter-rate clock, bit 2 the eighth-rate clock, and bit k toggles once every 2^k advancing rising edges.
- R2: `div_n_o` is at all times the bitwise inverse of `div_o`.
- R3: Whenever bit k of `div_o` changes (k > 0), every lower bit changes on the same rising edge.
- R4: The hold input is sampled on each falling input edge; the next rising edge advances the divider if and only if that sample was 0.
- R5: A rising edge that follows a falling-edge hold sample of 1 leaves `div_o` and `div_n_o` unchanged.
- R6: A rising edge with `rst_i` high drives every `div_o` bit to 0 and every `div_n_o` bit to 1, whatever the hold input; a falling edge with `rst_i` high clears the captured hold sample to 0.
- R7: The first advancing rising edge after reset sets all `div_o` bits to 1 on that same edge.
- R8: Away from reset, no output level lasts fewer than 2^k input cycles on `div_o[k]`, however the hold input is timed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset that aligns all stages |
| hold_i | input | 1 | Freeze request, captured on the falling edge of `clk_i` |
| div_o | output | STAGES | True divided clocks, bit k at 1/2^(k+1) of the input rate |
| div_n_o | output | STAGES | Complement of `div_o` |

## Verification
The assertions take for granted that `rst_i` is held high for at least one rising edge before any property is judged, since the stage state before the first reset is unknown. They also assume `rst_i` and `hold_i` settle away from the clock edges that sample them. The stimulus meets this by raising reset at time zero and by moving both inputs only at offsets between edges, spread over both clock phases so that hold changes land just before and just after the falling edge that captures them.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;

  // Default number of divide-by-two stages (half, quarter, eighth rate).
  parameter int unsigned DIV_STAGES_DEF = 3;

  // Reset level of each true output; complements reset to the inverse.
  parameter logic STAGE_RST_LEVEL = 1'b0;

  // Nominal half period, in input cycles, of stage k.
  function automatic int unsigned stage_half_period(input int unsigned k);
    return 32'd1 << k;
  endfunction

endpackage

// File: rtl/div_hold_capture.sv
// Captures the hold request on the falling input edge so that the
// advance decision is settled during the low phase of the input clock.
module div_hold_capture #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic hold_q_o
);

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      hold_q_o <= RST_VAL;
    end else begin
      hold_q_o <= hold_i;
    end
  end

endmodule

// File: rtl/div_borrow_chain.sv
// Toggle enables for a down-counting chain: stage k toggles when the
// divider advances and every lower stage currently reads 0.
module div_borrow_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              advance_i,
  input  logic [STAGES-1:0] state_i,
  output logic [STAGES-1:0] toggle_o
);

  assign toggle_o[0] = advance_i;

  for (genvar k = 1; k < STAGES; k++) begin : g_borrow
    assign toggle_o[k] = toggle_o[k-1] & ~state_i[k-1];
  end

endmodule

// File: rtl/div_toggle_stage.sv
// One divide-by-two stage with registered true and complement outputs.
module div_toggle_stage #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic toggle_i,
  output logic q_o,
  output logic q_n_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o   <= RST_VAL;
      q_n_o <= ~RST_VAL;
    end else if (toggle_i) begin
      q_o   <= ~q_o;
      q_n_o <= q_o;
    end
  end

endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hold_i,
  output logic [STAGES-1:0] div_o,
  output logic [STAGES-1:0] div_n_o
);

  localparam int unsigned MSB = STAGES - 1;

  logic              hold_q;
  logic              advance;
  logic [MSB:0]      toggle;

  div_hold_capture #(
    .RST_VAL (1'b0)
  ) u_hold (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hold_i   (hold_i),
    .hold_q_o (hold_q)
  );

  assign advance = ~hold_q;

  div_borrow_chain #(
    .STAGES (STAGES)
  ) u_chain (
    .advance_i (advance),
    .state_i   (div_o),
    .toggle_o  (toggle)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    div_toggle_stage #(
      .RST_VAL (STAGE_RST_LEVEL)
    ) u_stage (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .toggle_i (toggle[k]),
      .q_o      (div_o[k]),
      .q_n_o    (div_n_o[k])
    );
  end

endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk #(
  parameter int unsigned STAGES = 3
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              hold_q,
  input logic [STAGES-1:0] div_o,
  input logic [STAGES-1:0] div_n_o
);

  logic rst_d = 1'b0;

  always_ff @(posedge clk_i) begin
    rst_d <= rst_i;
    if (rst_d) begin
      AST_RESET_CLEARS: assert (div_o == '0 && div_n_o == '1); // R6
    end
  end

  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (rst_i)
    div_n_o == ~div_o); // R2

  AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_q |=> $stable(div_o)); // R5

  AST_ADVANCE_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
    !hold_q |=> div_o[0] != $past(div_o[0])); // R4

  AST_FIRST_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_o == '0 && !hold_q) |=> div_o == '1); // R7

  for (genvar k = 1; k < STAGES; k++) begin : g_align
    AST_EDGE_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
      (div_o[k] != $past(div_o[k])) |-> (div_o[k-1] != $past(div_o[k-1]))); // R3
  end

endmodule

bind pow2_clk_div pow2_clk_div_chk #(
  .STAGES (STAGES)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .hold_q  (hold_q),
  .div_o   (div_o),
  .div_n_o (div_n_o)
);

// File: tb/test_pow2_clk_div.sv
module test_pow2_clk_div;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         hold_i = 1'b1;
  logic [N-1:0] div_o;
  logic [N-1:0] div_n_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pow2_clk_div #(.STAGES(N)) i_pow2_clk_div (
    .clk_i   (clk),
    .rst_i   (rst_i),
    .hold_i  (hold_i),
    .div_o   (div_o),
    .div_n_o (div_n_o)
  );

  // Reference model: hold captured on falling edge, down-count on rising edge.
  logic         m_hold = 1'b0;
  logic [N-1:0] m_cnt = '0;
  bit           m_fresh = 0;
  bit           m_was_held = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always @(negedge clk) m_hold = rst_i ? 1'b0 : hold_i;

  task automatic predict();
    string t;
    if (rst_i) begin
      m_cnt = '0; m_fresh = 1; m_was_held = 0; t = "R6";
    end else if (m_hold) begin
      m_was_held = 1; t = "R5";
    end else begin
      if (m_fresh) t = "R7";
      else if (m_was_held) t = "R4";
      else t = "R1";
      m_cnt = m_cnt - 1'b1;
      m_fresh = 0; m_was_held = 0;
    end
    exp_q.push_back(m_cnt);
    tag_q.push_back(t);
  endtask

  always @(posedge clk) predict();

  // Monitor: pops expectations and checks outputs mid-cycle.
  logic [N-1:0] prev = '0;
  int           run_len[N];
  bit           armed[N];

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(div_o === e, t, div_o, e);
      check(div_n_o === ~e, "R2", div_n_o, ~e);
      if (t == "R6") begin
        for (int k = 0; k < N; k++) begin
          armed[k] = 0; run_len[k] = 1;
        end
      end else begin
        for (int k = 1; k < N; k++) begin
          if (div_o[k] != prev[k])
            check(div_o[k-1] != prev[k-1], "R3", div_o, prev);
        end
        for (int k = 0; k < N; k++) begin
          if (div_o[k] != prev[k]) begin
            if (armed[k])
              check(run_len[k] >= (1 << k), "R8", N'(run_len[k]), N'(1 << k));
            armed[k] = 1; run_len[k] = 1;
          end else begin
            run_len[k]++;
          end
        end
      end
      prev = div_o;
    end
  end

  // Stimulus: inputs move only at offsets that avoid both clock edges.
  task automatic drive(input logic r, input logic h, input int n, input int off);
    @(posedge clk);
    #(off);
    rst_i = r;
    hold_i = h;
    repeat (n - 1) @(posedge clk);
  endtask

  initial begin
    drive(1'b1, 1'b1, 3, 2);          // R6: reset wins over hold
    drive(1'b0, 1'b0, 24, 3);         // R7, R1: free run
    for (int i = 0; i < 40; i++) begin
      int off;
      off = 1 + (i * 7) % 9 + ((i % 2) * 10);
      drive(1'b0, 1'b1, 1 + (i % 5), off);      // R5, R8
      drive(1'b0, 1'b0, 1 + ((i * 3) % 7), 20 - off); // R4
    end
    drive(1'b1, 1'b1, 2, 14);         // R6: reset released after falling edge
    drive(1'b0, 1'b1, 3, 6);          // R5: held straight out of reset
    drive(1'b0, 1'b0, 40, 17);        // R7, R1, R3
    repeat (3) @(posedge clk);
    #7;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule